// File: doc/BRIEF.md
# Variable-Latency Multiply-Accumulate Unit

This block is a multi-cycle integer multiplier with a 64-bit accumulator. A one-cycle start pulse launches an operation in one of four modes: a 16x16 multiply, a 16x16 multiply-accumulate, a 32x32 multiply, or a 32x32 multiply-accumulate. Every mode is built on one shared 16x16 partial-product array. The 16-bit forms need one array pass. The 32-bit forms need four passes. The final pass also writes the accumulator, so each mode retires in a fixed number of cycles.

The operands, the mode and the signedness are captured at start. The accumulator is always readable as two 32-bit halves. Software-style control is limited to a clear input, which zeroes the accumulator while the unit is idle. Busy is high while an operation is in flight. Done pulses once when the result lands.

Top module: `vlmac_top`

## Requirements
- R1: With mode_i = 2'b00 (16x16 multiply), the accumulator is overwritten with the 64-bit extension of a_i[15:0] * b_i[15:0]. done_o rises 1 cycle after the clock edge that accepted start_i.
- R2: With mode_i = 2'b01 (16x16 accumulate), the 64-bit extended product of a_i[15:0] and b_i[15:0] is added to the accumulator. done_o rises 2 cycles after the accepting edge.
- R3: With mode_i = 2'b10 (32x32 multiply), the accumulator is overwritten with the 64-bit product of a_i and b_i. done_o rises 4 cycles after the accepting edge.
- R4: With mode_i = 2'b11 (32x32 accumulate), the 64-bit product of a_i and b_i is added to the accumulator. done_o rises 4 cycles after the accepting edge.
- R5: signed_i = 1 treats the operands as two's complement and sign-extends the product to 64 bits. signed_i = 0 treats them as unsigned and zero-extends. In the 16-bit modes, operand bits [31:16] have no effect.
- R6: Accumulation wraps modulo 2^64.
- R7: busy_o is high from the cycle after an accepted start up to, but not including, the done cycle. A start_i pulse while busy_o is high is ignored: the operands, mode, result and latency of the running operation are unchanged.
- R8: done_o is high for exactly one cycle per operation.
- R9: clear_i while idle zeroes the accumulator at the next edge. clear_i while busy_o is high is ignored. {acc_hi_o, acc_lo_o} always shows the 64-bit accumulator.
- R10: After reset, busy_o = 0, done_o = 0 and the accumulator is zero.
- R11: The accumulator holds its value while an operation is in flight and changes only at the edge that raises done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, accepted when idle |
| mode_i | input | 2 | Operation select (see R1 to R4) |
| signed_i | input | 1 | 1: two's-complement operands |
| a_i | input | 32 | Multiplicand |
| b_i | input | 32 | Multiplier |
| clear_i | input | 1 | Zero the accumulator when idle |
| busy_o | output | 1 | Operation in flight |
| done_o | output | 1 | One-cycle completion pulse |
| acc_hi_o | output | 32 | Accumulator bits [63:32] |
| acc_lo_o | output | 32 | Accumulator bits [31:0] |

## Verification
A wrong pass counter or latched mode shows up at the ports as a done pulse in the wrong cycle. It can also show up as a lost or doubled partial product, which is visible in the accumulator the same cycle done rises. A sign-extension slip in one half of an operand corrupts only the operand patterns that carry a set top bit, so the sweep crosses boundary values in both signednesses and all four modes. Busy-time inputs that leak in appear as a changed accumulator, either before done or in the done-cycle result.

// File: rtl/vlmac_pkg.sv
package vlmac_pkg;
  localparam int unsigned STEP_W = 3;

  typedef enum logic [1:0] {
    MODE_MUL16 = 2'b00,
    MODE_MAC16 = 2'b01,
    MODE_MUL32 = 2'b10,
    MODE_MAC32 = 2'b11
  } mode_e;

  // cycles from the accepting edge to the done edge
  function automatic logic [STEP_W-1:0] mode_steps(mode_e m);
    case (m)
      MODE_MUL16: return STEP_W'(1);
      MODE_MAC16: return STEP_W'(2);
      default:    return STEP_W'(4);
    endcase
  endfunction

  function automatic logic mode_is_acc(mode_e m);
    return m[0];
  endfunction

  function automatic logic mode_is_wide(mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/vlmac_ctrl.sv
module vlmac_ctrl
  import vlmac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mode_e             mode_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              launch_o,
  output logic              last_o,
  output logic [STEP_W-1:0] step_o,
  output mode_e             mode_o
);
  logic              busy_q, done_q;
  logic [STEP_W-1:0] step_q, lim_q;
  mode_e             mode_q;

  assign launch_o = start_i & ~busy_q;
  assign last_o   = busy_q && (step_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      lim_q  <= '0;
      mode_q <= MODE_MUL16;
    end else begin
      done_q <= last_o;
      if (launch_o) begin
        busy_q <= 1'b1;
        step_q <= STEP_W'(1);
        lim_q  <= mode_steps(mode_i);
        mode_q <= mode_i;
      end else if (last_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        step_q <= step_q + STEP_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign step_o = step_q;
  assign mode_o = mode_q;

  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R7
  busy_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> (busy_q && step_q == $past(step_q) + STEP_W'(1)));
  // R7
  launch_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && step_q == STEP_W'(1)));
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  // R4
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(step_q) == mode_steps($past(mode_q))));
endmodule

// File: rtl/vlmac_pp.sv
module vlmac_pp
  import vlmac_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [2*HALF_W-1:0] a_i,
  input  logic [2*HALF_W-1:0] b_i,
  input  logic                signed_i,
  input  logic                wide_i,
  input  logic [STEP_W-1:0]   step_i,
  output logic [4*HALF_W-1:0] pp_o
);
  localparam int unsigned OP_W   = 2 * HALF_W;
  localparam int unsigned ACC_W  = 4 * HALF_W;
  localparam int unsigned PROD_W = 2 * HALF_W + 2;
  localparam int unsigned SH_W   = $clog2(ACC_W);

  logic [OP_W-1:0] a_q, b_q;
  logic            sgn_q, wide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      sgn_q  <= 1'b0;
      wide_q <= 1'b0;
    end else if (load_i) begin
      a_q    <= a_i;
      b_q    <= b_i;
      sgn_q  <= signed_i;
      wide_q <= wide_i;
    end
  end

  // Extend each half by one bit. The top half, or the only half in the
  // 16-bit modes, carries the sign. The low half of a wide operand is
  // always unsigned.
  logic signed [HALF_W:0] a_x [2];
  logic signed [HALF_W:0] b_x [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam bit TOP = (h == 1);
    logic ext;
    assign ext    = sgn_q & (TOP ? 1'b1 : ~wide_q);
    assign a_x[h] = {ext & a_q[h*HALF_W+HALF_W-1], a_q[h*HALF_W +: HALF_W]};
    assign b_x[h] = {ext & b_q[h*HALF_W+HALF_W-1], b_q[h*HALF_W +: HALF_W]};
  end

  logic signed [HALF_W:0]   xa, xb;
  logic        [SH_W-1:0]   sh;
  logic signed [PROD_W-1:0] prod;
  logic        [ACC_W-1:0]  prod_ext;

  always_comb begin
    xa = '0;
    xb = '0;
    sh = '0;
    case (step_i)
      STEP_W'(1): begin
        xa = a_x[0];
        xb = b_x[0];
      end
      STEP_W'(2): if (wide_q) begin
        xa = a_x[0];
        xb = b_x[1];
        sh = SH_W'(HALF_W);
      end
      STEP_W'(3): if (wide_q) begin
        xa = a_x[1];
        xb = b_x[0];
        sh = SH_W'(HALF_W);
      end
      STEP_W'(4): if (wide_q) begin
        xa = a_x[1];
        xb = b_x[1];
        sh = SH_W'(2 * HALF_W);
      end
      default: ;
    endcase
  end

  assign prod     = PROD_W'(xa) * PROD_W'(xb);
  assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
  assign pp_o     = prod_ext << sh;

  // R5
  narrow_idle_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_q && step_i == STEP_W'(2)) |-> (pp_o == '0));
endmodule

// File: rtl/vlmac_acc.sv
module vlmac_acc #(
  parameter int unsigned ACC_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             busy_i,
  input  logic             launch_i,
  input  logic             last_i,
  input  logic             accum_i,
  input  logic [ACC_W-1:0] pp_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] prod_q, acc_q, base;

  assign base = accum_i ? acc_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
    end else if (launch_i) begin
      prod_q <= '0;
    end else if (busy_i && !last_i) begin
      prod_q <= prod_q + pp_i;
    end
  end

  // final pass folds the last partial product and the base into one add
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (last_i) begin
      acc_q <= base + prod_q + pp_i;
    end else if (clear_i && !busy_i) begin
      acc_q <= '0;
    end
  end

  assign acc_o = acc_q;

  // R9
  clear_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !busy_i) |=> (acc_q == '0));
  // R11
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !last_i) |=> $stable(acc_q));
  // R11
  acc_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !clear_i) |=> $stable(acc_q));
endmodule

// File: rtl/vlmac_top.sv
module vlmac_top
  import vlmac_pkg::*;
#(
  parameter int unsigned HALF_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          mode_i,
  input  logic                signed_i,
  input  logic [2*HALF_W-1:0] a_i,
  input  logic [2*HALF_W-1:0] b_i,
  input  logic                clear_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [2*HALF_W-1:0] acc_hi_o,
  output logic [2*HALF_W-1:0] acc_lo_o
);
  localparam int unsigned OP_W  = 2 * HALF_W;
  localparam int unsigned ACC_W = 4 * HALF_W;

  mode_e             mode_in, mode_q;
  logic              launch, last, busy;
  logic [STEP_W-1:0] step;
  logic [ACC_W-1:0]  pp, acc;

  assign mode_in = mode_e'(mode_i);

  vlmac_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mode_i   (mode_in),
    .busy_o   (busy),
    .done_o   (done_o),
    .launch_o (launch),
    .last_o   (last),
    .step_o   (step),
    .mode_o   (mode_q)
  );

  vlmac_pp #(.HALF_W(HALF_W)) u_pp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (launch),
    .a_i      (a_i),
    .b_i      (b_i),
    .signed_i (signed_i),
    .wide_i   (mode_is_wide(mode_in)),
    .step_i   (step),
    .pp_o     (pp)
  );

  vlmac_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .busy_i   (busy),
    .launch_i (launch),
    .last_i   (last),
    .accum_i  (mode_is_acc(mode_q)),
    .pp_i     (pp),
    .acc_o    (acc)
  );

  assign busy_o   = busy;
  assign acc_hi_o = acc[ACC_W-1:OP_W];
  assign acc_lo_o = acc[OP_W-1:0];
endmodule

// File: tb/vlmac_top_tb_top.sv
`timescale 1ns/1ps
module vlmac_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sgn = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        clear = 1'b0;
  logic        busy, done;
  logic [31:0] acc_hi, acc_lo;

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_acc = '0;

  always #2 clk = ~clk;

  vlmac_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .signed_i(sgn), .a_i(a), .b_i(b), .clear_i(clear),
    .busy_o(busy), .done_o(done), .acc_hi_o(acc_hi), .acc_lo_o(acc_lo)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] product(logic [1:0] m, logic s, logic [31:0] x, logic [31:0] y);
    logic [63:0] ex, ey;
    if (!m[1]) begin
      ex = s ? {{48{x[15]}}, x[15:0]} : {48'b0, x[15:0]};
      ey = s ? {{48{y[15]}}, y[15:0]} : {48'b0, y[15:0]};
    end else begin
      ex = s ? {{32{x[31]}}, x} : {32'b0, x};
      ey = s ? {{32{y[31]}}, y} : {32'b0, y};
    end
    return ex * ey;
  endfunction

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  // inj_s: start pulse with other inputs while busy; inj_c: clear while busy
  task automatic run_op(logic [1:0] m, logic s, logic [31:0] x, logic [31:0] y,
                        bit inj_s, bit inj_c);
    int n;
    int lat;
    logic [63:0] prev;
    lat = (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
    prev = exp_acc;
    exp_acc = (m[0] ? exp_acc : 64'h0) + product(m, s, x, y);
    @(negedge clk);
    start = 1'b1; mode = m; sgn = s; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", {63'b0, busy}, 64'h1);
    n = 0;
    while (!done && n < 16) begin
      if (n == 0 && inj_s) begin
        start = 1'b1; mode = ~m; sgn = ~s; a = ~x; b = y + 32'h1;
      end
      if (n == 0 && inj_c) clear = 1'b1;
      @(negedge clk);
      start = 1'b0;
      clear = 1'b0;
      n++;
      if (!done)
        chk({acc_hi, acc_lo} == prev, "R11 acc held while busy", {acc_hi, acc_lo}, prev);
    end
    chk(n == lat, {mode_tag(m), " latency"}, 64'(n), 64'(lat));
    chk({acc_hi, acc_lo} == exp_acc, {mode_tag(m), s ? " R5 signed" : " R5 unsigned", " result"},
        {acc_hi, acc_lo}, exp_acc);
    chk(acc_hi == exp_acc[63:32] && acc_lo == exp_acc[31:0], "R9 halves",
        {acc_hi, acc_lo}, exp_acc);
    chk(busy == 1'b0, "R7 busy low in done cycle", {63'b0, busy}, 64'h0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", {63'b0, done}, 64'h0);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    exp_acc = '0;
    chk({acc_hi, acc_lo} == 64'h0, "R9 clear when idle", {acc_hi, acc_lo}, 64'h0);
  endtask

  initial begin
    logic [31:0] vals [8];
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hffff_ffff;
    vals[3] = 32'h0000_7fff; vals[4] = 32'h0000_8000; vals[5] = 32'h7fff_ffff;
    vals[6] = 32'h8000_0000; vals[7] = 32'h9abc_1357;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R10 reset flags", {62'b0, busy, done}, 64'h0);
    chk({acc_hi, acc_lo} == 64'h0, "R10 reset acc", {acc_hi, acc_lo}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({acc_hi, acc_lo} == 64'h0 && !busy, "R10 after release", {acc_hi, acc_lo}, 64'h0);

    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        do_clear();
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            run_op(2'(m), 1'(s), vals[i], vals[j], 1'b0, 1'b0);
      end
    end

    // R6 wraparound
    do_clear();
    run_op(2'b10, 1'b0, 32'hffff_ffff, 32'hffff_ffff, 1'b0, 1'b0);
    run_op(2'b11, 1'b0, 32'hffff_ffff, 32'hffff_ffff, 1'b0, 1'b0);
    chk({acc_hi, acc_lo} == 64'hfffffffc_00000002, "R6 wrap",
        {acc_hi, acc_lo}, 64'hfffffffc_00000002);
    run_op(2'b01, 1'b1, 32'h0000_0001, 32'h0000_ffff, 1'b0, 1'b0);
    run_op(2'b01, 1'b1, 32'h0000_0002, 32'h0000_0002, 1'b0, 1'b0);

    // R7 start ignored and R9 clear refused while busy
    for (int m = 0; m < 4; m++) begin
      run_op(2'(m), 1'b1, 32'h8765_4321, 32'hfedc_ba98, 1'b1, 1'b0);
      run_op(2'(m), 1'b0, 32'h1357_9bdf, 32'h2468_ace0, 1'b0, 1'b1);
      run_op(2'(m), 1'b1, 32'hc0de_8001, 32'h7001_fffe, 1'b1, 1'b1);
    end

    // back-to-back starts
    for (int k = 0; k < 40; k++)
      run_op(2'(k % 4), 1'(k / 4 % 2), 32'(k * 32'h9e37_79b9), 32'(~k * 32'h85eb_ca6b), 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule